// File: doc/BRIEF.md
# Accumulator Processor Core with Interrupt Cycle

This block is a small processor core built around a single accumulator. Instructions and data share one word-addressed memory. The core reaches that memory only through an address holding register and a data buffer register. A control state machine steps through distinct phases:

- **Fetch:** the address holding register takes the program counter, memory is read, the counter is incremented, and the instruction register is loaded.
- **Decode.**
- **Execute:** a data read, a data write, or a change of the program counter.
- **Interrupt check:** after every completed instruction the core tests the request line. If it accepts the request, it saves the program counter and accumulator, disables further acceptance, pulses an acknowledge, and continues fetching at a fixed handler address. A return instruction brings the saved context back and enables acceptance again.

The memory port is synchronous. Address, write data and both strobes are registered outputs. Read data is expected on the cycle after a read strobe, as a registered block RAM delivers it. Instruction words carry the operation code in bits 15:12 and a 12-bit address in bits 11:0. Data words are sign-magnitude.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, `mem_rd`, `mem_wr`, `irq_ack` and `halted` are 0. After `rst` falls, the first instruction is fetched from address 0.
- R2: Each instruction fetch asserts `mem_rd` for exactly one cycle, with `mem_addr` equal to the program counter, in the second cycle of the instruction. The program counter then advances by one.
- R3: Opcode 0101 (bits 15:12) reads the word at the address in bits 11:0 into the accumulator.
- R4: Opcode 0001 adds the addressed word to the accumulator in sign-magnitude (bit 15 sign, bits 14:0 magnitude). The magnitude wraps modulo 2^15, and a zero result always has sign 0.
- R5: Opcode 0010 writes the accumulator to the addressed location with a single-cycle `mem_wr`. During that cycle `mem_wdata` holds the accumulator value.
- R6: Opcode 0000 stops the core. After it, `halted` stays 1 until reset, no further memory access occurs, and `irq_req` is ignored.
- R7: Opcode 0011 loads the program counter with bits 11:0. The word after the jump is not executed.
- R8: Once each instruction completes, a high `irq_req` with acceptance enabled causes `irq_ack` to be high for exactly one cycle. Execution then continues with a fetch from address 0xF00.
- R9: Acceptance is disabled while the handler runs. A request held high produces no further acknowledge until a return has completed.
- R10: Opcode 0100 restores the program counter and accumulator saved at entry and enables acceptance again. The interrupted program resumes at the instruction after the one it had completed.
- R11: Opcodes 0110 to 1111 are no-ops that only advance the program counter.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address (registered) |
| mem_rd | output | 1 | Read strobe; data expected on the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (registered) |
| mem_rdata | input | 16 | Read data from memory |
| irq_req | input | 1 | Interrupt request, level sensitive |
| irq_ack | output | 1 | One-cycle pulse when a request is accepted |
| halted | output | 1 | High once a stop instruction has executed |

## Verification
A return instruction can fall in the same cycle as the interrupt check that follows it. The return re-enables acceptance, so a request that is still pending is accepted immediately. The context saved at that point must therefore be the one just restored. The bench provokes this by holding the request high from the first acknowledge through the whole handler. It expects a second acknowledge right after the return and no acknowledge in between. Correctness is judged by comparing every bus cycle against the reference model, by the handler-entry counter in memory, and by the accumulator value the main program stores after resuming.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [3:0] OPC_STOP  = 4'h0;
  localparam logic [3:0] OPC_ADD   = 4'h1;
  localparam logic [3:0] OPC_STORE = 4'h2;
  localparam logic [3:0] OPC_JUMP  = 4'h3;
  localparam logic [3:0] OPC_RETI  = 4'h4;
  localparam logic [3:0] OPC_LOAD  = 4'h5;

  typedef enum logic [3:0] {
    ST_F_MAR,
    ST_F_RD,
    ST_F_MBR,
    ST_F_IR,
    ST_DEC,
    ST_X_RD,
    ST_X_MBR,
    ST_X_AC,
    ST_W_MEM,
    ST_ICHK,
    ST_HALT
  } cpu_state_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic pc_inc;
    logic pc_from_ir;
    logic mbr_from_mem;
    logic mbr_from_ac;
    logic ir_from_mbr;
    logic ac_from_mbr;
    logic ac_from_sum;
    logic ctx_save;
    logic ctx_restore;
  } dp_ctl_t;

endpackage

// File: rtl/acc_cpu_smadd.sv
module acc_cpu_smadd #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int MAG_W = W - 1;

  logic             sa, sb, sr;
  logic [MAG_W-1:0] ma, mb, mr;

  assign sa = a[W-1];
  assign sb = b[W-1];
  assign ma = a[MAG_W-1:0];
  assign mb = b[MAG_W-1:0];

  always_comb begin
    if (sa == sb) begin
      mr = ma + mb;
      sr = sa;
    end else if (ma >= mb) begin
      mr = ma - mb;
      sr = sa;
    end else begin
      mr = mb - ma;
      sr = sb;
    end
  end

  // zero is always positive
  assign y = {(mr != '0) ? sr : 1'b0, mr};

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int OPC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             irq_req,
  output dp_ctl_t          ctl,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             irq_ack,
  output logic             halted
);

  cpu_state_e state_q, state_d;
  logic rd_d, wr_d, ack_d, halt_d, ie_q, ie_d;

  always_comb begin
    state_d = state_q;
    ctl     = '0;
    rd_d    = 1'b0;
    wr_d    = 1'b0;
    ack_d   = 1'b0;
    halt_d  = halted;
    ie_d    = ie_q;
    case (state_q)
      ST_F_MAR: begin
        ctl.mar_from_pc = 1'b1;
        rd_d            = 1'b1;
        state_d         = ST_F_RD;
      end
      ST_F_RD: begin
        ctl.pc_inc = 1'b1;
        state_d    = ST_F_MBR;
      end
      ST_F_MBR: begin
        ctl.mbr_from_mem = 1'b1;
        state_d          = ST_F_IR;
      end
      ST_F_IR: begin
        ctl.ir_from_mbr = 1'b1;
        state_d         = ST_DEC;
      end
      ST_DEC: begin
        case (opcode)
          OPC_STOP: begin
            halt_d  = 1'b1;
            state_d = ST_HALT;
          end
          OPC_LOAD, OPC_ADD: begin
            ctl.mar_from_ir = 1'b1;
            rd_d            = 1'b1;
            state_d         = ST_X_RD;
          end
          OPC_STORE: begin
            ctl.mar_from_ir = 1'b1;
            ctl.mbr_from_ac = 1'b1;
            wr_d            = 1'b1;
            state_d         = ST_W_MEM;
          end
          OPC_JUMP: begin
            ctl.pc_from_ir = 1'b1;
            state_d        = ST_ICHK;
          end
          OPC_RETI: begin
            ctl.ctx_restore = 1'b1;
            ie_d            = 1'b1;
            state_d         = ST_ICHK;
          end
          default: state_d = ST_ICHK;
        endcase
      end
      ST_X_RD:  state_d = ST_X_MBR;
      ST_X_MBR: begin
        ctl.mbr_from_mem = 1'b1;
        state_d          = ST_X_AC;
      end
      ST_X_AC: begin
        if (opcode == OPC_ADD) ctl.ac_from_sum = 1'b1;
        else                   ctl.ac_from_mbr = 1'b1;
        state_d = ST_ICHK;
      end
      ST_W_MEM: state_d = ST_ICHK;
      ST_ICHK: begin
        if (ie_q && irq_req) begin
          ctl.ctx_save = 1'b1;
          ie_d         = 1'b0;
          ack_d        = 1'b1;
        end
        state_d = ST_F_MAR;
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_F_MAR;
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      irq_ack <= 1'b0;
      halted  <= 1'b0;
      ie_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      mem_rd  <= rd_d;
      mem_wr  <= wr_d;
      irq_ack <= ack_d;
      halted  <= halt_d;
      ie_q    <= ie_d;
    end
  end

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr)); // R12
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst) mem_rd |=> !mem_rd); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) irq_ack |=> !irq_ack); // R8
  AST_IE_CLEAR: assert property (@(posedge clk) disable iff (rst) irq_ack |-> !ie_q); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst) halted |=> halted); // R6
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst) halted |-> (!mem_rd && !mem_wr && !irq_ack)); // R6

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          OPC_W    = 4,
  parameter int unsigned VECTOR   = 'hF00,
  parameter int unsigned RESET_PC = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  dp_ctl_t                   ctl,
  input  logic [OPC_W+ADDR_W-1:0]   rdata,
  output logic [ADDR_W-1:0]         mar,
  output logic [OPC_W+ADDR_W-1:0]   mbr,
  output logic [OPC_W-1:0]          opcode,
  output logic [ADDR_W-1:0]         pc
);
  localparam int DATA_W = OPC_W + ADDR_W;

  logic [ADDR_W-1:0] pc_q, spc_q;
  logic [DATA_W-1:0] ir_q, ac_q, sac_q, sum;

  acc_cpu_smadd #(.W(DATA_W)) u_add (.a(ac_q), .b(mbr), .y(sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= ADDR_W'(RESET_PC);
      spc_q <= '0;
      mar   <= '0;
      mbr   <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
      sac_q <= '0;
    end else begin
      if (ctl.ctx_save) begin
        spc_q <= pc_q;
        sac_q <= ac_q;
        pc_q  <= ADDR_W'(VECTOR);
      end else if (ctl.ctx_restore) begin
        pc_q  <= spc_q;
      end else if (ctl.pc_from_ir) begin
        pc_q  <= ir_q[ADDR_W-1:0];
      end else if (ctl.pc_inc) begin
        pc_q  <= pc_q + ADDR_W'(1);
      end

      if (ctl.mar_from_pc)      mar <= pc_q;
      else if (ctl.mar_from_ir) mar <= ir_q[ADDR_W-1:0];

      if (ctl.mbr_from_mem)     mbr <= rdata;
      else if (ctl.mbr_from_ac) mbr <= ac_q;

      if (ctl.ir_from_mbr) ir_q <= mbr;

      if (ctl.ctx_restore)      ac_q <= sac_q;
      else if (ctl.ac_from_sum) ac_q <= sum;
      else if (ctl.ac_from_mbr) ac_q <= mbr;
    end
  end

  assign opcode = ir_q[DATA_W-1:ADDR_W];
  assign pc     = pc_q;

  AST_CTX_BACK: assert property (@(posedge clk) disable iff (rst)
    ctl.ctx_restore |=> (ac_q == $past(sac_q) && pc_q == $past(spc_q))); // R10
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_inc |=> pc_q == $past(pc_q) + ADDR_W'(1)); // R2

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          OPC_W    = 4,
  parameter int unsigned VECTOR   = 'hF00,
  parameter int unsigned RESET_PC = 0,
  localparam int         DATA_W   = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              irq_req,
  output logic              irq_ack,
  output logic              halted
);

  dp_ctl_t           ctl;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] pc;

  acc_cpu_ctrl #(.OPC_W(OPC_W)) u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .irq_req(irq_req), .ctl(ctl),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .irq_ack(irq_ack), .halted(halted)
  );

  acc_cpu_datapath #(
    .ADDR_W(ADDR_W), .OPC_W(OPC_W), .VECTOR(VECTOR), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .rdata(mem_rdata),
    .mar(mem_addr), .mbr(mem_wdata), .opcode(opcode), .pc(pc)
  );

  AST_ACK_VECTOR: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> pc == ADDR_W'(VECTOR)); // R8

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, irq_ack, halted;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        irq_req = 1'b0;

  always #10 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_req(irq_req),
    .irq_ack(irq_ack), .halted(halted)
  );

  logic [15:0] mem   [0:4095];
  logic [15:0] m_mem [0:4095];

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: instruction-level, expanded into per-cycle expectations
  typedef struct {
    bit rd; bit wr; int addr; int wdata; bit ack; bit halt; bit ichk;
  } exp_t;
  exp_t q[$];
  int m_pc = 0, m_ac = 0, m_spc = 0, m_sac = 0;
  bit m_ie = 1, m_halt = 0, pend_ack = 0;

  function automatic int sm_add(int a, int b);
    int va, vb, s, mag;
    va  = a[15] ? -(a & 'h7FFF) : (a & 'h7FFF);
    vb  = b[15] ? -(b & 'h7FFF) : (b & 'h7FFF);
    s   = va + vb;
    mag = (s < 0 ? -s : s) & 'h7FFF;
    return (mag != 0 && s < 0) ? (mag | 'h8000) : mag;
  endfunction

  task automatic push(bit rd, bit wr, int addr, int wdata, bit ack, bit halt, bit ichk);
    exp_t e;
    e.rd = rd; e.wr = wr; e.addr = addr; e.wdata = wdata;
    e.ack = ack; e.halt = halt; e.ichk = ichk;
    q.push_back(e);
  endtask

  task automatic gen();
    int w, op, a;
    if (m_halt) begin push(0, 0, 0, 0, 0, 1, 0); return; end
    w  = m_mem[m_pc];
    op = (w >> 12) & 'hF;
    a  = w & 'hFFF;
    push(0, 0, 0, 0, pend_ack, 0, 0);
    pend_ack = 0;
    push(1, 0, m_pc, 0, 0, 0, 0);
    repeat (3) push(0, 0, 0, 0, 0, 0, 0);
    m_pc = (m_pc + 1) & 'hFFF;
    case (op)
      0: m_halt = 1;
      5, 1: begin
        push(1, 0, a, 0, 0, 0, 0);
        repeat (2) push(0, 0, 0, 0, 0, 0, 0);
        push(0, 0, 0, 0, 0, 0, 1);
        m_ac = (op == 5) ? int'(m_mem[a]) : sm_add(m_ac, int'(m_mem[a]));
      end
      2: begin
        push(0, 1, a, m_ac, 0, 0, 0);
        push(0, 0, 0, 0, 0, 0, 1);
        m_mem[a] = m_ac[15:0];
      end
      3: begin m_pc = a; push(0, 0, 0, 0, 0, 0, 1); end
      4: begin
        m_pc = m_spc; m_ac = m_sac; m_ie = 1;
        push(0, 0, 0, 0, 0, 0, 1);
      end
      default: push(0, 0, 0, 0, 0, 0, 1);
    endcase
  endtask

  always @(negedge clk) begin
    exp_t e;
    cycles++;
    if (!rst) begin
      if (q.size() == 0) gen();
      e = q.pop_front();
      check(mem_rd == e.rd, "R2 mem_rd", mem_rd, e.rd);
      if (e.rd) check(mem_addr == e.addr[11:0], "R2/R3 read address", mem_addr, e.addr);
      check(mem_wr == e.wr, "R5 mem_wr", mem_wr, e.wr);
      if (e.wr) begin
        check(mem_addr == e.addr[11:0], "R5 write address", mem_addr, e.addr);
        check(mem_wdata == e.wdata[15:0], "R5 write data", mem_wdata, e.wdata);
      end
      check(irq_ack == e.ack, "R8 irq_ack", irq_ack, e.ack);
      check(halted == e.halt, "R6 halted", halted, e.halt);
      check(!(mem_rd && mem_wr), "R12 strobes exclusive", mem_rd & mem_wr, 0);
      if (e.ichk && m_ie && irq_req) begin
        m_spc = m_pc; m_sac = m_ac; m_pc = 'hF00; m_ie = 0; pend_ack = 1;
      end
    end
  end

  task automatic put(int a, int v);
    mem[a] = v[15:0];
    m_mem[a] = v[15:0];
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) put(i, 0);
    // main program
    put('h000, 'h5100); put('h001, 'h1101); put('h002, 'h2200);
    put('h003, 'h5102); put('h004, 'h1103); put('h005, 'h2201);
    put('h006, 'h5104); put('h007, 'h1105); put('h008, 'h2202);
    put('h009, 'h7000); put('h00A, 'hF123);
    put('h00B, 'h3020); put('h00C, 'h22FF);
    put('h020, 'h5106); put('h021, 'h1107); put('h022, 'h2203);
    put('h023, 'h5108);
    for (int i = 'h24; i < 'h2C; i++) put(i, 'h6ABC);
    put('h02C, 'h2207); put('h02D, 'h0000);
    // handler: count entries
    put('hF00, 'h5206); put('hF01, 'h1111); put('hF02, 'h2206); put('hF03, 'h4000);
    // data
    put('h100, 'h0003); put('h101, 'h0005);
    put('h102, 'h0004); put('h103, 'h8009);
    put('h104, 'h0007); put('h105, 'h8007);
    put('h106, 'h8003); put('h107, 'h8006);
    put('h108, 'h0042); put('h111, 'h0001);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!mem_rd && !mem_wr && !irq_ack && !halted, "R1 reset outputs",
          {mem_rd, mem_wr, irq_ack, halted}, 0);
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check(mem_rd && mem_addr == 12'h000, "R1 first fetch address", mem_addr, 0);

    // raise the request during the no-op stretch
    for (int i = 0; i < 3000 && !(mem_rd && mem_addr == 12'h024); i++) @(negedge clk);
    @(posedge clk); #2 irq_req = 1'b1;
    for (int i = 0; i < 3000 && !irq_ack; i++) @(negedge clk);
    check(irq_ack, "R8 first acknowledge", irq_ack, 1);
    @(negedge clk);
    // held request: next ack only after the return (R9, R10)
    for (int i = 0; i < 3000 && !irq_ack; i++) @(negedge clk);
    check(irq_ack, "R10 re-entry after return", irq_ack, 1);
    @(posedge clk); #2 irq_req = 1'b0;

    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    check(halted, "R6 halted reached", halted, 1);
    @(posedge clk); #2 irq_req = 1'b1;
    repeat (40) @(negedge clk);
    check(!irq_ack && halted, "R6 request ignored when stopped", irq_ack, 0);
    @(posedge clk); #2 irq_req = 1'b0;
    @(negedge clk);

    check(mem['h200] == 16'h0008, "R3/R4 positive sum", mem['h200], 'h0008);
    check(mem['h201] == 16'h8005, "R4 larger negative magnitude", mem['h201], 'h8005);
    check(mem['h202] == 16'h0000, "R4 cancel to +0", mem['h202], 0);
    check(mem['h203] == 16'h8009, "R4 both negative", mem['h203], 'h8009);
    check(mem['h2FF] == 16'h0000, "R7 skipped after jump", mem['h2FF], 0);
    check(mem['h206] == 16'h0002, "R9 handler entries", mem['h206], 2);
    check(mem['h207] == 16'h0042, "R10/R11 context restored after no-ops",
          mem['h207], 'h42);
    for (int i = 'h200; i < 'h210; i++)
      check(mem[i] == m_mem[i], "R5 memory image", mem[i], m_mem[i]);
    check(q.size() <= 1, "R6 model in step", q.size(), 1);
    finish_run();
  end

endmodule